// File: doc/BRIEF.md
# Pattern Window and Nametable Fold Mapper

This block sits on the picture-processor side of a cartridge mapper and translates every
14-bit picture-bus address into one of two physical addresses. The lower half of the
picture address space (bit 13 clear) holds pattern data. It is split into eight 1 KB
windows, and each window has its own 8-bit bank register, so the pattern memory can be up
to 256 KB. The upper half (bit 13 set) holds nametables. It is folded onto the console's
2 KB video RAM by one of four fold modes that software can change at run time. Two of
these modes are single-screen modes.

The bank registers and the fold mode are loaded from the processor side through a simple
write port. Only writes at address 0x6000 or above are decoded, and the low four address
bits pick the register. The translation itself is purely combinational, so a read and a
write at the same picture address resolve to the same physical location with no added
latency. The two memories are outside this block. The block drives both addresses at all
times, together with a select that says which memory the current access targets.

Top module: `ppu_bank_mapper`

## Requirements
- R1: `chr_sel` is 1 when `ppu_addr[13]` is 0 (pattern access) and 0 when `ppu_addr[13]` is 1 (nametable access), in the same cycle.
- R2: `chr_addr` equals {window register selected by `ppu_addr[12:10]`, `ppu_addr[9:0]`}, 18 bits, with the register value in bits [17:10].
- R3: A write with `cpu_addr` >= 0x6000 and `cpu_addr[3:0]` in 0..7 loads the full `cpu_wdata` byte into window register `cpu_addr[2:0]`. The new value is visible on `chr_addr` from the next clock edge.
- R4: A write with `cpu_addr` >= 0x6000 and `cpu_addr[3:0]` = 9 loads the fold mode from `cpu_wdata[1:0]`. The upper data bits are ignored.
- R5: `vram_addr[9:0]` equals `ppu_addr[9:0]`. `vram_addr[10]` is `ppu_addr[10]` in mode 0, `ppu_addr[11]` in mode 1, 0 in mode 2 and 1 in mode 3.
- R6: Writes with `cpu_addr` below 0x6000 change no window register and do not change the fold mode.
- R7: Writes at or above 0x6000 with `cpu_addr[3:0]` equal to 8 or in 0xA..0xF change no window register and do not change the fold mode. The upper address bits above 0x6000 do not affect which register is decoded.
- R8: A synchronous active-high `rst` clears all eight window registers to 0 and sets the fold mode to 0.
- R9: `chr_addr`, `vram_addr` and `chr_sel` follow a change of `ppu_addr` combinationally in the same cycle, and the same mapping serves reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor-side write strobe |
| cpu_addr | input | 16 | Processor-side write address |
| cpu_wdata | input | 8 | Processor-side write data |
| ppu_addr | input | 14 | Picture-bus address |
| chr_addr | output | 18 | Pattern memory address |
| vram_addr | output | 11 | Console video RAM address |
| chr_sel | output | 1 | 1 selects pattern memory, 0 selects video RAM |

## Verification
A wrong window register shows up only as wrong upper bits of `chr_addr`, and only while the picture address falls in that window. For this reason the bench sweeps all eight windows after each write pattern. A wrong fold mode shows up only in `vram_addr[10]`, and only for nametable addresses whose bits 10 and 11 differ from the forced value. Every mode is therefore probed with all four nametable quadrants. Because the translation has no pipeline, a corrupted register is visible on the very next access after the clock edge that corrupted it. A write decoded at the wrong offset appears within one cycle as a disturbed window or mode.

// File: rtl/ppu_map_pkg.sv
package ppu_map_pkg;

    parameter int unsigned PPU_AW    = 14;
    parameter int unsigned CPU_AW    = 16;
    parameter int unsigned CPU_DW    = 8;
    parameter int unsigned BANK_W    = 8;
    parameter int unsigned WIN_COUNT = 8;
    parameter int unsigned WIN_BITS  = 10;
    parameter int unsigned OFF_W     = 4;
    parameter int unsigned MODE_OFF  = 9;
    parameter logic [CPU_AW-1:0] REG_BASE = 16'h6000;

    localparam int unsigned SEL_W   = $clog2(WIN_COUNT);
    localparam int unsigned CHR_AW  = BANK_W + WIN_BITS;
    localparam int unsigned VRAM_AW = WIN_BITS + 1;
    localparam int unsigned SPLIT_B = WIN_BITS + SEL_W;

    typedef enum logic [1:0] {
        FOLD_BY_A10 = 2'd0,
        FOLD_BY_A11 = 2'd1,
        FOLD_LOW    = 2'd2,
        FOLD_HIGH   = 2'd3
    } fold_mode_e;

    typedef logic [WIN_COUNT-1:0][BANK_W-1:0] bank_file_t;

    typedef struct packed {
        logic              hit;
        logic [OFF_W-1:0]  off;
        logic [CPU_DW-1:0] data;
    } reg_wr_t;

    function automatic logic fold_bit(fold_mode_e mode, logic a10, logic a11);
        logic b;
        unique case (mode)
            FOLD_BY_A10: b = a10;
            FOLD_BY_A11: b = a11;
            FOLD_LOW:    b = 1'b0;
            default:     b = 1'b1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
    import ppu_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [CPU_DW-1:0] wr_data,
    output bank_file_t        banks,
    output fold_mode_e        mode
);

    reg_wr_t req;

    always_comb begin
        req.hit  = wr_en && (wr_addr >= REG_BASE);
        req.off  = wr_addr[OFF_W-1:0];
        req.data = wr_data;
    end

    for (genvar i = 0; i < WIN_COUNT; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                banks[i] <= '0;
            else if (req.hit && req.off == OFF_W'(i))
                banks[i] <= req.data[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= FOLD_BY_A10;
        else if (req.hit && req.off == OFF_W'(MODE_OFF))
            mode <= fold_mode_e'(req.data[1:0]);
    end

    // R3: window write lands in the addressed register
    a_r3_bank_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= REG_BASE && wr_addr[OFF_W-1] == 1'b0)
        |=> banks[$past(wr_addr[SEL_W-1:0])] == $past(wr_data));

    // R4: mode write takes the two low data bits
    a_r4_mode_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= REG_BASE && wr_addr[OFF_W-1:0] == OFF_W'(MODE_OFF))
        |=> mode == fold_mode_e'($past(wr_data[1:0])));

    // R6: writes below the base touch nothing
    a_r6_low_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr < REG_BASE) |=> ($stable(banks) && $stable(mode)));

    // R7: undecoded offsets touch nothing
    a_r7_gap_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= REG_BASE && wr_addr[OFF_W-1] == 1'b1
         && wr_addr[OFF_W-1:0] != OFF_W'(MODE_OFF))
        |=> ($stable(banks) && $stable(mode)));

    // R8: reset clears state
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (banks == '0 && mode == FOLD_BY_A10));

endmodule

// File: rtl/pattern_window.sv
module pattern_window
    import ppu_map_pkg::*;
(
    input  logic [SPLIT_B-1:0] pat_addr,
    input  bank_file_t         banks,
    output logic [CHR_AW-1:0]  chr_addr
);

    logic [SEL_W-1:0]  win;
    logic [BANK_W-1:0] bank_val;

    always_comb begin
        win      = pat_addr[SPLIT_B-1:WIN_BITS];
        bank_val = banks[win];
        chr_addr = {bank_val, pat_addr[WIN_BITS-1:0]};
    end

endmodule

// File: rtl/nametable_fold.sv
module nametable_fold
    import ppu_map_pkg::*;
(
    input  fold_mode_e          mode,
    input  logic [WIN_BITS+1:0] nt_addr,
    output logic [VRAM_AW-1:0]  vram_addr
);

    always_comb begin
        vram_addr = {fold_bit(mode, nt_addr[WIN_BITS], nt_addr[WIN_BITS+1]),
                     nt_addr[WIN_BITS-1:0]};
    end

endmodule

// File: rtl/ppu_bank_mapper.sv
module ppu_bank_mapper
    import ppu_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_wr_en,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [CPU_DW-1:0]  cpu_wdata,
    input  logic [PPU_AW-1:0]  ppu_addr,
    output logic [CHR_AW-1:0]  chr_addr,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic               chr_sel
);

    bank_file_t banks;
    fold_mode_e mode;

    mapper_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cpu_wr_en),
        .wr_addr (cpu_addr),
        .wr_data (cpu_wdata),
        .banks   (banks),
        .mode    (mode)
    );

    pattern_window u_pat (
        .pat_addr (ppu_addr[SPLIT_B-1:0]),
        .banks    (banks),
        .chr_addr (chr_addr)
    );

    nametable_fold u_nt (
        .mode      (mode),
        .nt_addr   (ppu_addr[WIN_BITS+1:0]),
        .vram_addr (vram_addr)
    );

    assign chr_sel = ~ppu_addr[PPU_AW-1];

    // R2: in-window offset reaches the pattern address untouched
    a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
        chr_addr[WIN_BITS-1:0] == ppu_addr[WIN_BITS-1:0]);

    // R5: low nametable bits reach video RAM untouched
    a_r5_low_pass: assert property (@(posedge clk) disable iff (rst)
        vram_addr[WIN_BITS-1:0] == ppu_addr[WIN_BITS-1:0]);

endmodule

// File: tb/sim_ppu_bank_mapper.sv
`timescale 1ns/1ps
module sim_ppu_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [13:0] ppu_addr = '0;
    logic [17:0] chr_addr;
    logic [10:0] vram_addr;
    logic        chr_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int ref_bank [8];
    int ref_mode;

    always #2.5 clk = ~clk;

    ppu_bank_mapper u0 (
        .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
        .vram_addr(vram_addr), .chr_sel(chr_sel)
    );

    // behavioural reference state
    always @(posedge clk) begin
        if (rst) begin
            foreach (ref_bank[k]) ref_bank[k] = 0;
            ref_mode = 0;
        end else if (cpu_wr_en && int'(cpu_addr) >= 'h6000) begin
            if (int'(cpu_addr % 16) < 8) ref_bank[cpu_addr % 16] = int'(cpu_wdata);
            else if (int'(cpu_addr % 16) == 9) ref_mode = int'(cpu_wdata) % 4;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_chr(int pa);
        return ref_bank[(pa / 1024) % 8] * 1024 + pa % 1024;
    endfunction

    function automatic int exp_vram(int pa);
        int b;
        case (ref_mode)
            0: b = (pa / 1024) % 2;
            1: b = (pa / 2048) % 2;
            2: b = 0;
            default: b = 1;
        endcase
        return b * 1024 + pa % 1024;
    endfunction

    // apply one cycle of stimulus, check the combinational outputs before the edge
    task automatic step(input string tag, input bit wr, input int ca, input int cd,
                        input int pa);
        @(negedge clk);
        cpu_wr_en = wr;
        cpu_addr  = ca[15:0];
        cpu_wdata = cd[7:0];
        ppu_addr  = pa[13:0];
        #1;
        checks++;
        if (int'(chr_sel) != ((pa / 8192) % 2 == 0 ? 1 : 0)) begin
            errors++;
            $display("FAIL %s chr_sel act=%0d exp=%0d pa=%h", tag, chr_sel,
                     (pa / 8192) % 2 == 0, pa);
        end
        checks++;
        if (int'(chr_addr) != exp_chr(pa)) begin
            errors++;
            $display("FAIL %s chr_addr act=%h exp=%h pa=%h", tag, chr_addr, exp_chr(pa), pa);
        end
        checks++;
        if (int'(vram_addr) != exp_vram(pa)) begin
            errors++;
            $display("FAIL %s vram_addr act=%h exp=%h pa=%h", tag, vram_addr,
                     exp_vram(pa), pa);
        end
    endtask

    task automatic sweep_windows(input string tag);
        for (int w = 0; w < 8; w++) step(tag, 0, 0, 0, w * 1024 + 37 * w + 5);
    endtask

    task automatic sweep_nt(input string tag);
        for (int q = 0; q < 4; q++) step(tag, 0, 0, 0, 'h2000 + q * 1024 + 3 * q + 1);
        for (int q = 0; q < 4; q++) step(tag, 0, 0, 0, 'h3000 + q * 1024 + 1023 - q);
    endtask

    initial begin
        // R8: reset state
        step("R8", 0, 0, 0, 0);
        step("R8", 1, 'h6003, 'h55, 'h0c00);
        @(negedge clk); rst = 0;
        sweep_windows("R8");
        sweep_nt("R8");

        // R3: load each window with a distinct byte
        for (int i = 0; i < 8; i++) step("R3", 1, 'h6000 + i, 'h1f * i + 'h0b, 'h1000);
        step("R3", 1, 'h6007, 'hff, 'h1c00);
        step("R2", 0, 0, 0, 'h1fff);
        sweep_windows("R2");

        // R9: address changes every cycle, same mapping for reads and writes
        for (int p = 0; p < 24; p++) step("R9", 0, 0, 0, (p * 'h2a7) % 'h4000);

        // R6: writes below the register base
        step("R6", 1, 'h5ff0, 'h33, 0);
        step("R6", 1, 'h5ff9, 'h03, 0);
        step("R6", 1, 'h0002, 'h77, 0);
        sweep_windows("R6");
        sweep_nt("R6");

        // R7: undecoded offsets and high alias addresses
        step("R7", 1, 'h6008, 'h44, 0);
        for (int o = 10; o < 16; o++) step("R7", 1, 'h6000 + o, 'hee, 0);
        sweep_windows("R7");
        sweep_nt("R7");
        step("R7", 1, 'hf005, 'hc3, 'h1400);
        step("R7", 0, 0, 0, 'h1400);

        // R4/R5: every fold mode, upper data bits set
        for (int m = 0; m < 4; m++) begin
            step("R4", 1, 'h8009, 'hfc + m, 'h2000);
            sweep_nt("R5");
        end
        step("R4", 1, 'h6009, 'h01, 'h2800);
        step("R5", 0, 0, 0, 'h2c00);
        step("R1", 0, 0, 0, 'h2000);
        step("R1", 0, 0, 0, 'h1fff);

        // R8: reset mid-run
        @(negedge clk); rst = 1;
        step("R8", 0, 0, 0, 0);
        @(negedge clk); rst = 0;
        sweep_windows("R8");
        sweep_nt("R8");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule